// File: doc/BRIEF.md
# Coherent Cycle Counter Read Port

This block keeps a free-running 64-bit count of system clocks and serves it to an instruction execution unit through a 32-bit read port. Each request picks one half of the count. The result comes back one cycle later, together with a one-cycle write-enable for the destination register.

A plain request returns the lower half of the count. A request with the high-half select returns the upper half of the count as it will stand a fixed number of cycles later. That offset, `ISSUE_GAP`, defaults to 2, which is the issue distance of two back-to-back two-cycle read instructions. Software can therefore read the upper half and then the lower half straight after, and the two words join into one consistent 64-bit value. No latch and no retry loop is needed, even when the lower half wraps between the two reads.

A high-half read also raises a marker saying that the carry flag must stay as it is. Neither kind of read produces a zero-flag result.

Top module: `cyc_ctr_reader`

## Requirements
- R1: While `rst` is high at a clock edge, the count loads `START_VAL` (default 0), and `rd_we`, `c_keep` and `rd_data` clear to 0.
- R2: After reset, the count rises by exactly one on every clock edge and wraps from all ones to zero across the full 64 bits.
- R3: A request with `rd_hi`=0 sampled at edge t makes `rd_data` equal bits [31:0] of the count held before edge t, visible from edge t on.
- R4: A request with `rd_hi`=1 sampled at edge t makes `rd_data` equal bits [63:32] of (count before edge t + `ISSUE_GAP`), visible from edge t on.
- R5: A high request at edge t followed by a low request at edge t+`ISSUE_GAP` yields {high result, low result} equal to the count before edge t+`ISSUE_GAP`. This includes pairs that straddle a wrap of the lower half or of the whole count.
- R6: `rd_we` is high for exactly the one cycle after each sampled request and is never high without one.
- R7: `c_keep` is high together with `rd_we` for high-half results and low for low-half results and whenever `rd_we` is low.
- R8: While no result is being delivered, `rd_data` keeps the last delivered word.
- R9: Requests on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read strobe, sampled on the rising edge |
| rd_hi | input | 1 | 1 selects the compensated upper half, 0 the lower half |
| rd_data | output | 32 | Selected word, registered |
| rd_we | output | 1 | Destination write-enable, one cycle per request |
| c_keep | output | 1 | Marks a high-half result: the carry flag stays unchanged |

## Verification
A count that is off by one, or that skips a cycle, shows in the very next result word. The bench keeps its own count of clocks from reset and compares each returned word against it. A wrong compensation offset leaves each read correct on its own, so it only shows when a high read is joined with the following low read. Pairs are therefore issued at shifting phases around the lower-half wrap and the full 64-bit wrap, where a tear changes the upper word by one. A stray or missing write-enable shows one cycle after the strobe, and a corrupted hold of the result shows on the next idle cycle.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;
  localparam int CYC_W  = 64;
  localparam int HALF_W = 32;

  typedef logic [CYC_W-1:0]  cyc_t;
  typedef logic [HALF_W-1:0] half_t;

  // lower half of the live count
  function automatic half_t lo_half(input cyc_t c);
    return c[HALF_W-1:0];
  endfunction

  // upper half of the count as it will be 'gap' cycles later
  function automatic half_t hi_half_ahead(input cyc_t c, input cyc_t gap);
    cyc_t ahead;
    ahead = c + gap;
    return ahead[CYC_W-1:HALF_W];
  endfunction
endpackage

// File: rtl/cyc_ctr_count.sv
module cyc_ctr_count
  import cyc_ctr_pkg::*;
#(
  parameter cyc_t START_VAL = '0
) (
  input  logic clk,
  input  logic rst,
  output cyc_t cnt,
  output logic live
);
  cyc_t cnt_q;
  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= START_VAL;
      live_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + cyc_t'(1);
      live_q <= 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign live = live_q;

  // R2: one step per clock once out of reset
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> cnt_q == $past(cnt_q) + cyc_t'(1));
endmodule

// File: rtl/cyc_ctr_pick.sv
module cyc_ctr_pick
  import cyc_ctr_pkg::*;
#(
  parameter int ISSUE_GAP = 2
) (
  input  cyc_t  cnt,
  input  logic  sel_hi,
  output half_t word
);
  localparam cyc_t GAP_C = cyc_t'(ISSUE_GAP);

  half_t lo_w;
  half_t hi_w;

  always_comb begin
    lo_w = lo_half(cnt);
    hi_w = hi_half_ahead(cnt, GAP_C);
    word = sel_hi ? hi_w : lo_w;
  end
endmodule

// File: rtl/cyc_ctr_reader.sv
module cyc_ctr_reader
  import cyc_ctr_pkg::*;
#(
  parameter int   ISSUE_GAP = 2,
  parameter cyc_t START_VAL = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        rd_hi,
  output logic [31:0] rd_data,
  output logic        rd_we,
  output logic        c_keep
);
  cyc_t  cnt;
  logic  live;
  half_t pick_word;
  half_t data_q;
  logic  we_q;
  logic  keep_q;

  cyc_ctr_count #(.START_VAL(START_VAL)) u_count (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .live (live)
  );

  cyc_ctr_pick #(.ISSUE_GAP(ISSUE_GAP)) u_pick (
    .cnt    (cnt),
    .sel_hi (rd_hi),
    .word   (pick_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      we_q   <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      we_q   <= rd_req;
      keep_q <= rd_req & rd_hi;
      if (rd_req) data_q <= pick_word;
    end
  end

  assign rd_data = data_q;
  assign rd_we   = we_q;
  assign c_keep  = keep_q;

  // R6: write-enable mirrors the strobe one cycle late
  assert_we_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
    live |-> rd_we == $past(rd_req));

  // R7: the keep-carry marker only rides on a delivered result
  assert_keep_needs_we_R7: assert property (@(posedge clk) disable iff (rst)
    c_keep |-> rd_we);

  // R3: low result equals the count at the request edge
  assert_low_word_R3: assert property (@(posedge clk) disable iff (rst)
    (live && rd_we && !c_keep) |-> rd_data == $past(cnt[31:0]));

  // R8: result word holds while nothing is delivered
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (live && !rd_we) |-> $stable(rd_data));
endmodule

// File: tb/cyc_ctr_reader_tb_top.sv
`timescale 1ns/1ps
module cyc_ctr_reader_tb_top;
  localparam int          GAP   = 2;
  localparam logic [63:0] START = 64'hFFFF_FFFF_FFFF_FFC0;

  typedef struct packed {
    logic [31:0] d;
    logic        hi;
    logic        coh;
    logic [63:0] full;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic        rd_hi = 1'b0;
  logic [31:0] rd_data;
  logic        rd_we;
  logic        c_keep;

  int checks = 0;
  int errors = 0;
  logic [63:0] m;
  exp_t q[$];
  logic [31:0] last_data = '0;
  logic [31:0] prev_hi = '0;
  bit done = 0;

  cyc_ctr_reader #(.ISSUE_GAP(GAP), .START_VAL(START)) dut_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_hi(rd_hi),
    .rd_data(rd_data), .rd_we(rd_we), .c_keep(c_keep)
  );

  always #10 clk = ~clk;

  // reference count kept by the bench
  always @(posedge clk) m <= rst ? START : m + 64'd1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected result
  task automatic cyc(input bit en, input bit hi, input bit coh);
    exp_t e;
    logic [63:0] ahead;
    @(negedge clk);
    rd_req = en;
    rd_hi  = hi;
    if (en) begin
      ahead  = m + 64'(GAP);
      e.hi   = hi;
      e.coh  = coh;
      e.full = m;
      e.d    = hi ? ahead[63:32] : m[31:0];
      q.push_back(e);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        if (rd_we) begin
          if (q.size() == 0) begin
            chk(1'b0, "R6 stray write-enable", 64'(rd_we), 64'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.hi) chk(rd_data == e.d, "R4 high word", 64'(rd_data), 64'(e.d));
            else      chk(rd_data == e.d, "R3 low word", 64'(rd_data), 64'(e.d));
            chk(c_keep == e.hi, "R7 keep-carry marker", 64'(c_keep), 64'(e.hi));
            if (e.coh) chk({prev_hi, rd_data} == e.full, "R5 coherent pair",
                           {prev_hi, rd_data}, e.full);
            if (e.hi) prev_hi = rd_data;
          end
          last_data = rd_data;
        end else begin
          chk(rd_data == last_data, "R8 hold when idle", 64'(rd_data), 64'(last_data));
          chk(c_keep == 1'b0, "R7 marker low when idle", 64'(c_keep), 64'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, sampled before any request is served
    chk(rd_we == 1'b0, "R1 write-enable after reset", 64'(rd_we), 64'd0);
    chk(c_keep == 1'b0, "R1 marker after reset", 64'(c_keep), 64'd0);
    chk(rd_data == 32'd0, "R1 data after reset", 64'(rd_data), 64'd0);
    // R1/R2: first low read returns the start value plus elapsed cycles
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    // R5: high/low pairs at shifting phases through the low and full wrap
    for (int i = 0; i < 40; i++) begin
      cyc(1, 1, 0);
      for (int g = 1; g < GAP; g++) cyc(0, 0, 0);
      cyc(1, 0, 1);
      for (int k = 0; k < (i % 3) + 1; k++) cyc(0, 0, 0);
    end
    // R9: back-to-back requests every cycle, alternating halves
    for (int i = 0; i < 12; i++) cyc(1, i[0], 0);
    // R3: isolated low reads with gaps
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      cyc(0, 0, 0);
    end
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    @(posedge clk);
    #5;
    // R6: every request got exactly one result
    chk(q.size() == 0, "R6 pending results", 64'(q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule